// File: doc/BRIEF.md
# Four-Lane Serial DAC Interface Controller

This block drives a dual-channel 16-bit digital-to-analog converter over a serial bus with four data lanes. It works in one of two modes. In register mode it runs a single read or write of an 8-bit or 16-bit device register. In stream mode it sends channel sample pairs back to back for as long as streaming is requested. Each transfer can use single data rate (one nibble per serial clock period) or double data rate (one nibble per serial clock edge), and the choice is made per command.

Every transaction opens with an instruction byte. Bit 7 is the read flag and bits 6:0 are the register address, and the byte always goes out at single data rate. Configuration transfers run the serial clock at one eighth of the reference clock. Streaming runs it at one half, so a 16-bit word is sent every 8 reference clocks at single rate and every 4 at double rate. The reference clock is meant to run at up to 132 MHz. Data lanes are brought out as separate output, input and output-enable signals so that an external I/O buffer can be attached. The block contains no register file, DMA or pad buffers.

Top module: `qspi_dac_ctrl`

## Requirements
- R1: After reset csN is 1, sclk is 0, padOe is 0, busy is 0, done is 0, sampleReady is 0 and rdData is 0.
- R2: The instruction byte is {read flag, cmdAddr[6:0]}. It is sent as two nibbles, high nibble first, on sdo with sdo[3] carrying the most significant bit of the nibble. Each nibble lasts CFG_DIV reference clocks in register mode, whatever cmdDdr says.
- R3: In register mode the serial clock runs at 1/CFG_DIV of the reference clock. A single-rate nibble holds sclk low for the first half of its CFG_DIV clocks and high for the second half. A double-rate nibble lasts CFG_DIV/2 clocks, with sclk held steady and inverted relative to the previous nibble. sclk is 0 whenever csN is high.
- R4: A write sends cmdWdata[7:0] as 2 nibbles when cmdWide=0, or cmdWdata[15:0] as 4 nibbles when cmdWide=1, most significant nibble first, right after the instruction.
- R5: During the data phase of a read, padOe is 0. It is 1 during the instruction and during write data. sdi is sampled on the last reference clock of each nibble and shifted into rdData MSB first. An 8-bit read is zero-extended. rdData changes only during reads.
- R6: csN falls on the clock edge that accepts cmdStart and rises on the edge that ends the last nibble. busy equals the inverse of csN. done is a one-cycle pulse in the cycle right after csN rises.
- R7: cmdStart and all command fields are ignored while busy is 1.
- R8: In stream mode the instruction read bit is forced to 0, and the instruction goes out at single rate with 2-clock nibbles. Each sample pair follows as chA[15:0] and then chB[15:0], most significant nibble first. A nibble lasts 2 clocks at single rate (a word every 8 clocks) and 1 clock at double rate (a word every 4 clocks, with sclk toggling every clock).
- R9: sampleReady is 1 only in the last clock of the instruction and in the last clock of each sample pair, and only while cmdStream is 1. A pair is taken on that edge when sampleValid is also 1.
- R10: If sampleValid is 0 at a pair boundary, the previously sent pair is sent again. If no pair has been taken yet in the current stream, zeros are sent.
- R11: Stream mode ends only at a pair boundary where cmdStream is 0. On that edge csN rises and done pulses.
- R12: csN stays low from the instruction through the last pair of a stream.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rstN | input | 1 | Asynchronous active-low reset |
| cmdStart | input | 1 | Starts a transaction when the block is idle |
| cmdAddr | input | 7 | Register address for the instruction byte |
| cmdWdata | input | 16 | Write data (low byte used for 8-bit writes) |
| cmdWide | input | 1 | 1 selects 16-bit register data, 0 selects 8-bit |
| cmdRead | input | 1 | 1 selects a register read |
| cmdDdr | input | 1 | 1 selects double data rate for the data phase |
| cmdStream | input | 1 | Selects stream mode at start; held high to keep streaming |
| chA | input | 16 | Channel A sample, sent first |
| chB | input | 16 | Channel B sample, sent second |
| sampleValid | input | 1 | Sample pair on chA/chB is valid |
| sampleReady | output | 1 | Pair boundary; pair taken when sampleValid is also 1 |
| busy | output | 1 | A transaction is in progress |
| done | output | 1 | One-cycle pulse at the end of a transaction |
| rdData | output | 16 | Data assembled by the last register read |
| sclk | output | 1 | Serial clock |
| csN | output | 1 | Active-low chip select |
| sdo | output | 4 | Serial data out, lane 3 most significant |
| sdi | input | 4 | Serial data in, lane 3 most significant |
| padOe | output | 1 | 1 drives the data lanes, 0 releases them |

## Verification
If cmdStart is sampled at edge S, csN and the first sdo nibble appear right after S. Each later nibble appears at S plus the summed lengths of the nibbles before it: CFG_DIV clocks per instruction nibble in register mode, and 2 in stream mode. So csN rises at S + 2·CFG_DIV + nData·L, with done and rdData valid in that following cycle. The bench samples each nibble and the lane direction at the first falling edge of its beat. It drives sdi at that same falling edge, so the value is stable at the capture edge that closes the beat. It looks at sampleReady only at the falling edge inside the last clock of each segment, and counts sclk rising edges and high cycles over the whole transfer to confirm both clock rates.

// File: rtl/qspi_dac_pkg.sv
package qspi_dac_pkg;
  localparam int LANES   = 4;
  localparam int WORD_W  = 16;
  localparam int ADDR_W  = 7;
  localparam int INSTR_W = ADDR_W + 1;
  localparam int SHIFT_W = 2 * WORD_W;
  localparam int PAIR_NIBS  = SHIFT_W / LANES;
  localparam int INSTR_NIBS = INSTR_W / LANES;
  localparam int NIB_W   = $clog2(PAIR_NIBS);

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_INSTR,
    ST_DATA,
    ST_STREAM
  } ctlState_t;

  typedef struct packed {
    logic loadCmd;
    logic shift;
    logic loadPair;
    logic capture;
    logic sclkLow;
    logic sclkHigh;
    logic sclkFlip;
    logic csAssert;
    logic csRelease;
    logic oeOn;
    logic oeOff;
  } dpCtl_t;
endpackage

// File: rtl/qspi_dac_ctl.sv
module qspi_dac_ctl
  import qspi_dac_pkg::*;
#(
  parameter int CFG_DIV    = 8,
  parameter int STREAM_DIV = 2
) (
  input  logic   clk,
  input  logic   rstN,
  input  logic   cmdStart,
  input  logic   cmdRead,
  input  logic   cmdWide,
  input  logic   cmdDdr,
  input  logic   cmdStream,
  output dpCtl_t ctl,
  output logic   sampleReady,
  output logic   busy,
  output logic   done
);
  localparam int CNT_W = (CFG_DIV > 2) ? $clog2(CFG_DIV) : 1;
  localparam int LEN_W = CNT_W + 1;

  ctlState_t        state, stateNx;
  logic [CNT_W-1:0] beatCnt, beatNx;
  logic [NIB_W-1:0] nibCnt, nibNx;
  logic             modeRead, modeWide, modeDdr, modeStream;
  logic             doneNx;
  logic [LEN_W-1:0] beatLen;
  logic             sdrBeat, beatEnd, midHit, lastNib, endTxn;

  always_comb begin
    case (state)
      ST_INSTR:  beatLen = modeStream ? LEN_W'(STREAM_DIV) : LEN_W'(CFG_DIV);
      ST_DATA:   beatLen = modeDdr ? LEN_W'(CFG_DIV / 2) : LEN_W'(CFG_DIV);
      ST_STREAM: beatLen = modeDdr ? LEN_W'(STREAM_DIV / 2) : LEN_W'(STREAM_DIV);
      default:   beatLen = LEN_W'(CFG_DIV);
    endcase
  end

  always_comb begin
    case (state)
      ST_INSTR:  lastNib = (nibCnt == NIB_W'(INSTR_NIBS - 1));
      ST_DATA:   lastNib = modeWide ? (nibCnt == NIB_W'(WORD_W / LANES - 1))
                                    : (nibCnt == NIB_W'(INSTR_W / LANES - 1));
      ST_STREAM: lastNib = (nibCnt == NIB_W'(PAIR_NIBS - 1));
      default:   lastNib = 1'b0;
    endcase
  end

  assign sdrBeat = (state == ST_INSTR) || !modeDdr;
  assign beatEnd = ({1'b0, beatCnt} == beatLen - LEN_W'(1));
  assign midHit  = sdrBeat && ({1'b0, beatCnt} == (beatLen >> 1) - LEN_W'(1));

  always_comb begin
    ctl         = '0;
    stateNx     = state;
    beatNx      = beatCnt + CNT_W'(1);
    nibNx       = nibCnt;
    doneNx      = 1'b0;
    sampleReady = 1'b0;
    endTxn      = 1'b0;
    if (state == ST_IDLE) begin
      beatNx = '0;
      nibNx  = '0;
      if (cmdStart) begin
        ctl.loadCmd  = 1'b1;
        ctl.csAssert = 1'b1;
        ctl.oeOn     = 1'b1;
        ctl.sclkLow  = 1'b1;
        stateNx      = ST_INSTR;
      end
    end else begin
      if (midHit) ctl.sclkHigh = 1'b1;
      if (state == ST_DATA && modeRead && beatEnd) ctl.capture = 1'b1;
      if (beatEnd) begin
        beatNx = '0;
        nibNx  = nibCnt + NIB_W'(1);
        if (!lastNib) begin
          ctl.shift = 1'b1;
          if (sdrBeat) ctl.sclkLow = 1'b1;
          else         ctl.sclkFlip = 1'b1;
        end else if (state == ST_INSTR && !modeStream) begin
          stateNx   = ST_DATA;
          nibNx     = '0;
          ctl.shift = 1'b1;
          if (modeRead) ctl.oeOff = 1'b1;
          if (modeDdr) ctl.sclkFlip = 1'b1;
          else         ctl.sclkLow = 1'b1;
        end else if (state != ST_DATA && cmdStream) begin
          sampleReady  = 1'b1;
          ctl.loadPair = 1'b1;
          stateNx      = ST_STREAM;
          nibNx        = '0;
          if (modeDdr) ctl.sclkFlip = 1'b1;
          else         ctl.sclkLow = 1'b1;
        end else begin
          endTxn = 1'b1;
        end
      end
      if (endTxn) begin
        stateNx       = ST_IDLE;
        ctl.csRelease = 1'b1;
        ctl.sclkLow   = 1'b1;
        ctl.oeOff     = 1'b1;
        doneNx        = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state      <= ST_IDLE;
      beatCnt    <= '0;
      nibCnt     <= '0;
      done       <= 1'b0;
      modeRead   <= 1'b0;
      modeWide   <= 1'b0;
      modeDdr    <= 1'b0;
      modeStream <= 1'b0;
    end else begin
      state   <= stateNx;
      beatCnt <= beatNx;
      nibCnt  <= nibNx;
      done    <= doneNx;
      if (ctl.loadCmd) begin
        modeRead   <= cmdRead;
        modeWide   <= cmdWide;
        modeDdr    <= cmdDdr;
        modeStream <= cmdStream;
      end
    end
  end

  assign busy = (state != ST_IDLE);
endmodule

// File: rtl/qspi_dac_dp.sv
module qspi_dac_dp
  import qspi_dac_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  dpCtl_t            ctl,
  input  logic [ADDR_W-1:0] cmdAddr,
  input  logic [WORD_W-1:0] cmdWdata,
  input  logic              cmdWide,
  input  logic              cmdRead,
  input  logic              cmdStream,
  input  logic [WORD_W-1:0] chA,
  input  logic [WORD_W-1:0] chB,
  input  logic              sampleValid,
  input  logic [LANES-1:0]  sdi,
  output logic [LANES-1:0]  sdo,
  output logic              sclk,
  output logic              csN,
  output logic              padOe,
  output logic [WORD_W-1:0] rdData
);
  localparam int PAD_W  = SHIFT_W - INSTR_W - WORD_W;
  localparam int HALF_W = WORD_W / 2;

  logic [SHIFT_W-1:0] shifter, pairReg;
  logic [INSTR_W-1:0] instr;
  logic [WORD_W-1:0]  dataAligned;
  logic               isRegRead;

  assign isRegRead   = cmdRead && !cmdStream;
  assign instr       = {isRegRead, cmdAddr};
  assign dataAligned = cmdWide ? cmdWdata : {cmdWdata[HALF_W-1:0], {HALF_W{1'b0}}};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shifter <= '0;
      pairReg <= '0;
      rdData  <= '0;
    end else begin
      if (ctl.loadCmd) begin
        pairReg <= '0;
        if (cmdStream) shifter <= {instr, {(SHIFT_W - INSTR_W){1'b0}}};
        else           shifter <= {instr, dataAligned, {PAD_W{1'b0}}};
        if (isRegRead) rdData <= '0;
      end
      if (ctl.shift) shifter <= shifter << LANES;
      if (ctl.loadPair) begin
        if (sampleValid) begin
          shifter <= {chA, chB};
          pairReg <= {chA, chB};
        end else begin
          shifter <= pairReg;
        end
      end
      if (ctl.capture) rdData <= {rdData[WORD_W-LANES-1:0], sdi};
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclk  <= 1'b0;
      csN   <= 1'b1;
      padOe <= 1'b0;
    end else begin
      if (ctl.sclkLow)       sclk <= 1'b0;
      else if (ctl.sclkHigh) sclk <= 1'b1;
      else if (ctl.sclkFlip) sclk <= ~sclk;
      if (ctl.csAssert)       csN <= 1'b0;
      else if (ctl.csRelease) csN <= 1'b1;
      if (ctl.oeOn)       padOe <= 1'b1;
      else if (ctl.oeOff) padOe <= 1'b0;
    end
  end

  assign sdo = shifter[SHIFT_W-1 -: LANES];
endmodule

// File: rtl/qspi_dac_ctrl.sv
module qspi_dac_ctrl
  import qspi_dac_pkg::*;
#(
  parameter int CFG_DIV    = 8,
  parameter int STREAM_DIV = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cmdStart,
  input  logic [ADDR_W-1:0] cmdAddr,
  input  logic [WORD_W-1:0] cmdWdata,
  input  logic              cmdWide,
  input  logic              cmdRead,
  input  logic              cmdDdr,
  input  logic              cmdStream,
  input  logic [WORD_W-1:0] chA,
  input  logic [WORD_W-1:0] chB,
  input  logic              sampleValid,
  output logic              sampleReady,
  output logic              busy,
  output logic              done,
  output logic [WORD_W-1:0] rdData,
  output logic              sclk,
  output logic              csN,
  output logic [LANES-1:0]  sdo,
  input  logic [LANES-1:0]  sdi,
  output logic              padOe
);
  dpCtl_t ctl;

  qspi_dac_ctl #(
    .CFG_DIV   (CFG_DIV),
    .STREAM_DIV(STREAM_DIV)
  ) uCtl (
    .clk        (clk),
    .rstN       (rstN),
    .cmdStart   (cmdStart),
    .cmdRead    (cmdRead),
    .cmdWide    (cmdWide),
    .cmdDdr     (cmdDdr),
    .cmdStream  (cmdStream),
    .ctl        (ctl),
    .sampleReady(sampleReady),
    .busy       (busy),
    .done       (done)
  );

  qspi_dac_dp uDp (
    .clk        (clk),
    .rstN       (rstN),
    .ctl        (ctl),
    .cmdAddr    (cmdAddr),
    .cmdWdata   (cmdWdata),
    .cmdWide    (cmdWide),
    .cmdRead    (cmdRead),
    .cmdStream  (cmdStream),
    .chA        (chA),
    .chB        (chB),
    .sampleValid(sampleValid),
    .sdi        (sdi),
    .sdo        (sdo),
    .sclk       (sclk),
    .csN        (csN),
    .padOe      (padOe),
    .rdData     (rdData)
  );
endmodule

// File: rtl/qspi_dac_chk.sv
module qspi_dac_chk
  import qspi_dac_pkg::*;
(
  input logic              clk,
  input logic              rstN,
  input logic              cmdStart,
  input logic              sampleReady,
  input logic              busy,
  input logic              done,
  input logic [WORD_W-1:0] rdData,
  input logic              sclk,
  input logic              csN,
  input logic              padOe
);
  AST_CS_MATCHES_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    busy == !csN); // R6

  AST_DONE_ON_RELEASE: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (csN && !$past(csN))); // R6

  AST_READY_IN_TXN: assert property (@(posedge clk) disable iff (!rstN)
    sampleReady |-> (busy && !csN)); // R9

  AST_OE_INSIDE_CS: assert property (@(posedge clk) disable iff (!rstN)
    padOe |-> !csN); // R5

  AST_SCLK_IDLE_LOW: assert property (@(posedge clk) disable iff (!rstN)
    csN |-> !sclk); // R3

  AST_RDDATA_HELD_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    (csN && $past(csN)) |-> $stable(rdData)); // R5

  AST_START_NO_RESTART: assert property (@(posedge clk) disable iff (!rstN)
    (busy && cmdStart && !csN) |=> (!done || csN)); // R7
endmodule

bind qspi_dac_ctrl qspi_dac_chk uChk (
  .clk        (clk),
  .rstN       (rstN),
  .cmdStart   (cmdStart),
  .sampleReady(sampleReady),
  .busy       (busy),
  .done       (done),
  .rdData     (rdData),
  .sclk       (sclk),
  .csN        (csN),
  .padOe      (padOe)
);

// File: tb/tb_qspi_dac_ctrl.sv
module tb_qspi_dac_ctrl;
  localparam int CFG = 8;
  localparam int STR = 2;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cmdStart = 1'b0;
  logic [6:0]  cmdAddr = '0;
  logic [15:0] cmdWdata = '0;
  logic        cmdWide = 1'b0;
  logic        cmdRead = 1'b0;
  logic        cmdDdr = 1'b0;
  logic        cmdStream = 1'b0;
  logic [15:0] chA = '0;
  logic [15:0] chB = '0;
  logic        sampleValid = 1'b0;
  logic        sampleReady, busy, done, sclk, csN, padOe;
  logic [15:0] rdData;
  logic [3:0]  sdo;
  logic [3:0]  sdi = '0;

  int checks = 0;
  int failures = 0;

  logic [31:0] segData [4];
  logic        segVal  [4];

  always #4 clk = ~clk;

  qspi_dac_ctrl #(.CFG_DIV(CFG), .STREAM_DIV(STR)) dut (
    .clk(clk), .rstN(rstN), .cmdStart(cmdStart), .cmdAddr(cmdAddr),
    .cmdWdata(cmdWdata), .cmdWide(cmdWide), .cmdRead(cmdRead), .cmdDdr(cmdDdr),
    .cmdStream(cmdStream), .chA(chA), .chB(chB), .sampleValid(sampleValid),
    .sampleReady(sampleReady), .busy(busy), .done(done), .rdData(rdData),
    .sclk(sclk), .csN(csN), .sdo(sdo), .sdi(sdi), .padOe(padOe)
  );

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic checkReset();
    chk("R1", "csN", 32'(csN), 1);
    chk("R1", "sclk", 32'(sclk), 0);
    chk("R1", "padOe", 32'(padOe), 0);
    chk("R1", "busy", 32'(busy), 0);
    chk("R1", "done", 32'(done), 0);
    chk("R1", "sampleReady", 32'(sampleReady), 0);
    chk("R1", "rdData", 32'(rdData), 0);
  endtask

  task automatic regAccess(input logic rd, input logic wide, input logic ddr,
                           input logic [6:0] addr, input logic [15:0] wdata,
                           input logic [15:0] model, input logic poke);
    logic [7:0]  instr;
    logic [15:0] dWord, mWord;
    int nData, rises, highs, nSdr, nDdr;
    logic prevSclk;
    instr = {rd, addr};
    nData = wide ? 4 : 2;
    dWord = wide ? wdata : {wdata[7:0], 8'h00};
    mWord = wide ? model : {model[7:0], 8'h00};
    rises = 0; highs = 0; prevSclk = 1'b0;
    @(negedge clk);
    cmdAddr = addr; cmdWdata = wdata; cmdWide = wide; cmdRead = rd;
    cmdDdr = ddr; cmdStream = 1'b0; cmdStart = 1'b1;
    @(negedge clk);
    cmdStart = 1'b0;
    chk("R6", "busy after start", 32'(busy), 1);
    for (int b = 0; b < 2 + nData; b++) begin
      int len;
      logic [3:0] expNib;
      len = (b < 2) ? CFG : (ddr ? CFG / 2 : CFG);
      if (b < 2) expNib = 4'(instr >> (4 * (1 - b)));
      else       expNib = 4'(dWord >> (4 * (5 - b)));
      for (int c = 0; c < len; c++) begin
        if (c == 0) begin
          chk("R6", "csN low in transfer", 32'(csN), 0);
          if (b < 2) begin
            chk("R2", "instruction nibble", 32'(sdo), 32'(expNib));
            chk("R5", "padOe drives instr", 32'(padOe), 1);
          end else if (!rd) begin
            chk("R4", "write nibble", 32'(sdo), 32'(expNib));
            chk("R5", "padOe drives write", 32'(padOe), 1);
          end else begin
            chk("R5", "padOe released on read", 32'(padOe), 0);
            sdi = 4'(mWord >> (4 * (5 - b)));
          end
        end
        if (poke && b == 1 && c == 0) begin
          cmdStart = 1'b1; cmdAddr = 7'h7F; cmdRead = ~rd; cmdWdata = 16'hFFFF;
        end
        if (poke && b == 1 && c == 1) cmdStart = 1'b0;
        if (sclk && !prevSclk) rises++;
        if (sclk) highs++;
        prevSclk = sclk;
        @(negedge clk);
      end
    end
    nSdr = 2 + (ddr ? 0 : nData);
    nDdr = ddr ? nData : 0;
    chk("R6", "csN released", 32'(csN), 1);
    chk("R6", "done pulse", 32'(done), 1);
    chk("R6", "busy cleared", 32'(busy), 0);
    chk("R3", "sclk idle low", 32'(sclk), 0);
    chk("R3", "sclk rising edges", 32'(rises), 32'(nSdr + nDdr / 2));
    chk("R3", "sclk high cycles", 32'(highs), 32'(nSdr * CFG / 2 + (nDdr / 2) * (CFG / 2)));
    if (rd) chk("R5", "read data", 32'(rdData), wide ? 32'(model) : 32'(model[7:0]));
    @(negedge clk);
    chk("R6", "done one cycle", 32'(done), 0);
    sdi = '0;
    if (poke) begin
      repeat (3) @(negedge clk);
      chk("R7", "no restart from ignored start", 32'(busy), 0);
      chk("R7", "csN stays high", 32'(csN), 1);
    end
  endtask

  task automatic streamRun(input logic ddr, input logic rdBit,
                           input logic [6:0] addr, input int nSeg);
    logic [7:0]  instr;
    logic [31:0] sent;
    int rises, readyCnt, hs, expHs, totalBeats;
    logic prevSclk;
    instr = {1'b0, addr};
    sent = '0; rises = 0; readyCnt = 0; hs = 0; expHs = 0; prevSclk = 1'b0;
    for (int k = 0; k < nSeg; k++) if (segVal[k]) expHs++;
    totalBeats = 2 + 8 * nSeg;
    @(negedge clk);
    chA = segData[0][31:16]; chB = segData[0][15:0]; sampleValid = segVal[0];
    cmdAddr = addr; cmdRead = rdBit; cmdDdr = ddr; cmdStream = 1'b1; cmdStart = 1'b1;
    @(negedge clk);
    cmdStart = 1'b0;
    for (int b = 0; b < totalBeats; b++) begin
      int seg, nib, len;
      seg = (b < 2) ? -1 : (b - 2) / 8;
      nib = (b < 2) ? b : (b - 2) % 8;
      len = (b < 2) ? STR : (ddr ? STR / 2 : STR);
      for (int c = 0; c < len; c++) begin
        if (c == 0) begin
          chk("R12", "csN low across stream", 32'(csN), 0);
          if (seg < 0) begin
            chk("R8", "stream instruction nibble", 32'(sdo), 32'(4'(instr >> (4 * (1 - b)))));
          end else begin
            if (nib == 0) begin
              if (segVal[seg]) sent = segData[seg];
              if (seg + 1 < nSeg) begin
                chA = segData[seg + 1][31:16]; chB = segData[seg + 1][15:0];
                sampleValid = segVal[seg + 1];
              end else begin
                cmdStream = 1'b0; sampleValid = 1'b0;
              end
            end
            if (segVal[seg]) chk("R8", "stream sample nibble", 32'(sdo), 32'(4'(sent >> (28 - 4 * nib))));
            else chk("R10", "repeated pair nibble", 32'(sdo), 32'(4'(sent >> (28 - 4 * nib))));
          end
        end
        if (c == len - 1 && ((seg < 0 && nib == 1) || (seg >= 0 && nib == 7))) begin
          if (seg < nSeg - 1) chk("R9", "ready at pair boundary", 32'(sampleReady), 1);
          else chk("R11", "no ready at exit boundary", 32'(sampleReady), 0);
        end
        if (sampleReady) readyCnt++;
        if (sampleReady && sampleValid) hs++;
        if (sclk && !prevSclk) rises++;
        prevSclk = sclk;
        @(negedge clk);
      end
    end
    chk("R11", "csN released at boundary", 32'(csN), 1);
    chk("R11", "done at stream exit", 32'(done), 1);
    chk("R9", "ready pulse count", 32'(readyCnt), 32'(nSeg));
    chk("R9", "pairs taken", 32'(hs), 32'(expHs));
    chk("R8", "stream sclk rising edges", 32'(rises), 32'(2 + nSeg * (ddr ? 4 : 8)));
    chk("R3", "sclk low after stream", 32'(sclk), 0);
    @(negedge clk);
    chk("R6", "done one cycle after stream", 32'(done), 0);
    cmdRead = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    checkReset();
    rstN = 1'b1;
    @(negedge clk);
    checkReset();

    regAccess(1'b0, 1'b0, 1'b0, 7'h2A, 16'h12C3, 16'h0000, 1'b0);
    regAccess(1'b0, 1'b1, 1'b1, 7'h11, 16'hBEEF, 16'h0000, 1'b0);
    chk("R5", "write leaves rdData", 32'(rdData), 0);
    regAccess(1'b1, 1'b1, 1'b0, 7'h45, 16'h0000, 16'h9A5C, 1'b0);
    regAccess(1'b1, 1'b0, 1'b1, 7'h03, 16'h0000, 16'hE637, 1'b0);
    regAccess(1'b0, 1'b0, 1'b0, 7'h5B, 16'h00A6, 16'h0000, 1'b1);
    chk("R5", "rdData kept after write", 32'(rdData), 32'h0037);

    segData[0] = 32'h1234_ABCD; segVal[0] = 1'b1;
    segData[1] = 32'h5678_0F1E; segVal[1] = 1'b1;
    segData[2] = 32'hDEAD_DEAD; segVal[2] = 1'b0;
    segData[3] = 32'h9C3A_7E21; segVal[3] = 1'b1;
    streamRun(1'b0, 1'b0, 7'h2C, 4);

    segData[0] = 32'hFFFF_FFFF; segVal[0] = 1'b0;
    segData[1] = 32'hC0DE_4B5A; segVal[1] = 1'b1;
    streamRun(1'b1, 1'b1, 7'h2C, 2);

    repeat (2) @(negedge clk);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule